// File: doc/BRIEF.md
# Hybrid Local/Global Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two direction predictors side by side and picks one of them per lookup. The local side first reads a per-branch history of recent outcomes, selected by low PC bits. That history then addresses a table of 3-bit saturating counters. The global side addresses a table of 2-bit saturating counters with one shift register that holds the most recent outcomes of every resolved branch. A third table of 2-bit saturating counters, addressed by the same global history, decides which of the two guesses to trust.

The fetch stage drives a PC on the lookup port. In the same cycle it receives the final guess, both component guesses and the selector's choice. When a branch resolves, the pipeline presents its PC and real outcome with a valid strobe. On the next clock edge the block trains both component counters and the selector, then shifts the outcome into both histories. Every training decision uses the state as it stood before that update.

Top module: `tourney_pred`

## Requirements
- R1: While reset is asserted and directly after it is released, every lookup output is 0 for any PC. In this state every local counter is 3, every global counter is 1, every selector counter is 1 and every history is 0.
- R2: The local guess is the MSB of the 3-bit counter addressed by the local history entry. That history entry is selected by PC bits [ALIGN+LHT_IDX_W-1:ALIGN].
- R3: A local counter steps up on a taken outcome and down on a not-taken outcome. It holds at 7 and at 0 instead of wrapping.
- R4: The global history holds the newest outcome in bit 0 and shifts one place left on each valid update. The global guess is the MSB of the 2-bit counter it addresses, and that counter saturates at 3 and 0.
- R5: The selector counter is addressed by the global history. When its MSB is 1 it picks the global guess, and lk_use_global shows that bit. lk_pred carries the chosen guess.
- R6: The selector counter changes only when exactly one component guessed right. It steps up, saturating at 3, when the global guess was right, and steps down, saturating at 0, when the local guess was right.
- R7: On a valid update, the local history entry of up_pc shifts the outcome in at bit 0. All counters are trained at the indices that existed before the update.
- R8: While up_valid is 0, no table or history changes, whatever up_pc and up_taken hold.
- R9: Lookup outputs are combinational on lk_pc and the stored state. An update becomes visible to lookups only after the clock edge that takes it.
- R10: The default parameters give a 1K-entry 10-bit local history table, a 1K-entry local counter table, and 4K-entry global and selector tables on a 12-bit global history. PCs whose bits [11:2] differ therefore use separate local histories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | PC being looked up |
| lk_pred | output | 1 | Final taken guess |
| lk_local | output | 1 | Local component guess |
| lk_global | output | 1 | Global component guess |
| lk_use_global | output | 1 | Selector picks the global guess |
| up_valid | input | 1 | Resolved branch present |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Real outcome of the resolved branch |

## Verification
The hardest state to reach is one where a selector counter has saturated, or where one component is right while the other is wrong. That only happens after the local history, the global history and the counters have evolved together over many updates. The stimulus repeats a short trace of correlated branches, alternating branches and loop-closing branches many times, so that histories repeat and counters settle. A behavioural model written from the requirements follows the same trace and predicts all four outputs at every step. Directed runs add a fixed always-taken stream that drives both counter types past their limits, and a PC alias test on the default-size instance.

// File: rtl/tourney_pred.sv
module tourney_pred #(
  parameter int PC_W      = 32,
  parameter int ALIGN     = 2,
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10,
  parameter int GHIST_W   = 12,
  parameter int LCTR_W    = 3,
  parameter int GCTR_W    = 2,
  parameter int SEL_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_pred,
  output logic            lk_local,
  output logic            lk_global,
  output logic            lk_use_global,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int LHT_N = 1 << LHT_IDX_W;
  localparam int LCT_N = 1 << LHIST_W;
  localparam int GCT_N = 1 << GHIST_W;
  localparam logic [LCTR_W-1:0] LC_INIT = LCTR_W'((1 << (LCTR_W-1)) - 1);
  localparam logic [GCTR_W-1:0] GC_INIT = GCTR_W'((1 << (GCTR_W-1)) - 1);
  localparam logic [SEL_W-1:0]  SL_INIT = SEL_W'((1 << (SEL_W-1)) - 1);

  logic [LHIST_W-1:0] lht [LHT_N];
  logic [LCTR_W-1:0]  lct [LCT_N];
  logic [GCTR_W-1:0]  gct [GCT_N];
  logic [SEL_W-1:0]   sel [GCT_N];
  logic [GHIST_W-1:0] ghist;

  wire [LHT_IDX_W-1:0] lk_li = lk_pc[ALIGN +: LHT_IDX_W];
  assign lk_local      = lct[lht[lk_li]][LCTR_W-1];
  assign lk_global     = gct[ghist][GCTR_W-1];
  assign lk_use_global = sel[ghist][SEL_W-1];
  assign lk_pred       = lk_use_global ? lk_global : lk_local;

  wire [LHT_IDX_W-1:0] up_li   = up_pc[ALIGN +: LHT_IDX_W];
  wire [LHIST_W-1:0]   up_hist = lht[up_li];
  wire [LCTR_W-1:0]    up_lc   = lct[up_hist];
  wire [GCTR_W-1:0]    up_gc   = gct[ghist];
  wire [SEL_W-1:0]     up_sl   = sel[ghist];
  wire loc_ok = (up_lc[LCTR_W-1] == up_taken);
  wire glb_ok = (up_gc[GCTR_W-1] == up_taken);

  logic [LCTR_W-1:0] lc_nxt;
  logic [GCTR_W-1:0] gc_nxt;
  logic [SEL_W-1:0]  sl_nxt;

  always_comb begin
    lc_nxt = up_lc;
    if (up_taken && up_lc != '1) lc_nxt = up_lc + 1'b1;
    else if (!up_taken && up_lc != '0) lc_nxt = up_lc - 1'b1;
    gc_nxt = up_gc;
    if (up_taken && up_gc != '1) gc_nxt = up_gc + 1'b1;
    else if (!up_taken && up_gc != '0) gc_nxt = up_gc - 1'b1;
    sl_nxt = up_sl;
    if (loc_ok != glb_ok) begin
      if (glb_ok && up_sl != '1) sl_nxt = up_sl + 1'b1;
      else if (loc_ok && up_sl != '0) sl_nxt = up_sl - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LHT_N; i++) lht[i] <= '0;
    end else if (up_valid) begin
      lht[up_li] <= {up_hist[LHIST_W-2:0], up_taken};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LCT_N; i++) lct[i] <= LC_INIT;
    end else if (up_valid) begin
      lct[up_hist] <= lc_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < GCT_N; i++) begin
        gct[i] <= GC_INIT;
        sel[i] <= SL_INIT;
      end
    end else if (up_valid) begin
      gct[ghist] <= gc_nxt;
      sel[ghist] <= sl_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ghist <= '0;
    else if (up_valid) ghist <= {ghist[GHIST_W-2:0], up_taken};
  end
endmodule

// File: rtl/tourney_pred_chk.sv
module tourney_pred_chk #(
  parameter int PW = 32,
  parameter int GW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] lk_pc,
  input logic          lk_pred,
  input logic          lk_local,
  input logic          lk_global,
  input logic          lk_use_global,
  input logic          up_valid,
  input logic          up_taken,
  input logic [GW-1:0] ghist
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!lk_pred && !lk_local && !lk_global && !lk_use_global));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(up_valid) && $stable(lk_pc)) |->
      $stable({lk_pred, lk_local, lk_global, lk_use_global}));

  // R4
  ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (ghist == {$past(ghist[GW-2:0]), $past(up_taken)}));

  // R8
  ghist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist));
endmodule

bind tourney_pred tourney_pred_chk #(.PW(PC_W), .GW(GHIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_pred(lk_pred),
  .lk_local(lk_local), .lk_global(lk_global), .lk_use_global(lk_use_global),
  .up_valid(up_valid), .up_taken(up_taken), .ghist(ghist)
);

// File: tb/tourney_pred_bench.sv
module tourney_pred_bench;
  logic clk = 0;
  always #2 clk = ~clk;

  logic       rst_n = 0;
  logic [7:0] lk_pc = 0, up_pc = 0;
  logic       up_valid = 0, up_taken = 0;
  logic       lk_pred, lk_local, lk_global, lk_use_global;

  tourney_pred #(.PC_W(8), .ALIGN(2), .LHT_IDX_W(3), .LHIST_W(3), .GHIST_W(4))
    u_tourney_pred (.clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_pred(lk_pred),
      .lk_local(lk_local), .lk_global(lk_global), .lk_use_global(lk_use_global),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  logic [31:0] d_lk_pc = 0, d_up_pc = 0;
  logic        d_up_valid = 0, d_up_taken = 0;
  logic        d_pred, d_local, d_global, d_use_g;

  tourney_pred u_tourney_pred_dflt (.clk(clk), .rst_n(rst_n), .lk_pc(d_lk_pc),
    .lk_pred(d_pred), .lk_local(d_local), .lk_global(d_global),
    .lk_use_global(d_use_g), .up_valid(d_up_valid), .up_pc(d_up_pc),
    .up_taken(d_up_taken));

  int checks = 0, errors = 0;

  // {taken, pc}
  localparam logic [8:0] VEC [16] = '{
    9'h110, 9'h114, 9'h120, 9'h010, 9'h014, 9'h120, 9'h120, 9'h020,
    9'h110, 9'h114, 9'h12C, 9'h010, 9'h014, 9'h02C, 9'h130, 9'h034};

  logic [2:0] m_lht [8];
  logic [2:0] m_lc  [8];
  logic [1:0] m_gc  [16];
  logic [1:0] m_ch  [16];
  logic [3:0] m_gh;

  task automatic m_reset();
    for (int i = 0; i < 8; i++) begin m_lht[i] = 0; m_lc[i] = 3; end
    for (int i = 0; i < 16; i++) begin m_gc[i] = 1; m_ch[i] = 1; end
    m_gh = 0;
  endtask

  task automatic m_update(input logic [7:0] pc, input logic t);
    logic [2:0] li, h;
    logic lg, gg;
    li = pc[4:2];
    h  = m_lht[li];
    lg = m_lc[h][2];
    gg = m_gc[m_gh][1];
    if (t && m_lc[h] != 7) m_lc[h] = m_lc[h] + 1;
    else if (!t && m_lc[h] != 0) m_lc[h] = m_lc[h] - 1;
    if (t && m_gc[m_gh] != 3) m_gc[m_gh] = m_gc[m_gh] + 1;
    else if (!t && m_gc[m_gh] != 0) m_gc[m_gh] = m_gc[m_gh] - 1;
    if ((lg == t) && (gg != t) && m_ch[m_gh] != 0) m_ch[m_gh] = m_ch[m_gh] - 1;
    if ((lg != t) && (gg == t) && m_ch[m_gh] != 3) m_ch[m_gh] = m_ch[m_gh] + 1;
    m_lht[li] = {h[1:0], t};
    m_gh = {m_gh[2:0], t};
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cmp_model(input string tag);
    logic el, eg, es;
    el = m_lc[m_lht[lk_pc[4:2]]][2];
    eg = m_gc[m_gh][1];
    es = m_ch[m_gh][1];
    chk({tag, " local"}, lk_local, el);
    chk({tag, " global"}, lk_global, eg);
    chk({tag, " use_global"}, lk_use_global, es);
    chk({tag, " pred"}, lk_pred, es ? eg : el);
  endtask

  task automatic do_update(input logic [7:0] pc, input logic t);
    @(negedge clk);
    up_valid = 1; up_pc = pc; up_taken = t;
    @(posedge clk);
    m_update(pc, t);
    @(negedge clk);
    up_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; m_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    // R1: outputs during and after reset
    lk_pc = 8'h1C; #1;
    chk("R1 in reset pred", lk_pred, 0);
    chk("R1 in reset use_global", lk_use_global, 0);
    rst_n = 1;
    for (int p = 0; p < 8; p++) begin
      @(negedge clk); lk_pc = 8'(p * 4); #1;
      chk("R1 local", lk_local, 0);
      chk("R1 global", lk_global, 0);
      chk("R1 use_global", lk_use_global, 0);
      chk("R1 pred", lk_pred, 0);
    end

    // R9: lookup combinational, update visible after the edge
    @(negedge clk);
    lk_pc = 8'h04; up_valid = 1; up_pc = 8'h00; up_taken = 1; #1;
    chk("R9 before edge local", lk_local, 0);
    @(posedge clk); m_update(8'h00, 1);
    @(negedge clk); up_valid = 0; #1;
    chk("R9 after edge local", lk_local, 1);
    chk("R9 after edge pred", lk_pred, 1);
    cmp_model("R7");

    // R3/R4/R6: always-taken stream past the counter limits
    do_reset();
    for (int k = 0; k < 8; k++) do_update(8'h00, 1);
    @(negedge clk); lk_pc = 8'h00; #1;
    chk("R3 local saturated at 7", lk_local, 1);
    chk("R4 global saturated at 3", lk_global, 1);
    chk("R6 selector stays local", lk_use_global, 0);
    chk("R5 pred follows local", lk_pred, 1);
    cmp_model("R3");

    // R2/R4/R5/R6/R7: trace walk against the model
    do_reset();
    for (int r = 0; r < 30; r++) begin
      for (int v = 0; v < 16; v++) begin
        @(negedge clk); lk_pc = VEC[v][7:0]; #1;
        cmp_model("R2/R4/R5/R6");
        do_update(VEC[v][7:0], VEC[v][8]);
      end
    end

    // R8: stray update data without valid
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); up_valid = 0; up_pc = 8'(k * 12); up_taken = k[0];
    end
    for (int p = 0; p < 8; p++) begin
      @(negedge clk); lk_pc = 8'(p * 4); #1;
      cmp_model("R8");
    end

    // R1: reset in the middle of a run
    do_reset();
    for (int p = 0; p < 8; p++) begin
      @(negedge clk); lk_pc = 8'(p * 4); #1;
      chk("R1 mid-run local", lk_local, 0);
      chk("R1 mid-run global", lk_global, 0);
      chk("R1 mid-run use_global", lk_use_global, 0);
    end

    // R10/R2: default sizes, 10 PC bits select the local history
    @(negedge clk); d_up_valid = 1; d_up_pc = 32'h0; d_up_taken = 1;
    @(negedge clk); d_up_pc = 32'h4;
    @(negedge clk); d_up_valid = 0;
    d_lk_pc = 32'h800; #1;
    chk("R10 separate entry local", d_local, 1);
    @(negedge clk); d_lk_pc = 32'h1000; #1;
    chk("R10 aliased entry local", d_local, 0);
    chk("R10 aliased entry pred", d_pred, 0);

    finish_run();
  end
endmodule